// File: doc/BRIEF.md
# SPI Register Slave with Packet Buffer

This block is the host-facing end of a radio transceiver's control path. An external controller drives a four-wire SPI link in Mode 0 (clock idles low, data sampled on the rising edge, MSB first). Each chip-select window opens with a command byte: bit 7 chooses write (1) or read (0), and bits 6:0 name a 7-bit register address. Every later byte in the same window moves one data byte. For most addresses the register address then steps to the next one, so a configuration block can be written or read in a single burst.

Address 0x00 is a window onto a 256-byte packet buffer. In a burst at this address the register address stays put, and a separate 8-bit buffer pointer at 0x0D steps after each byte instead. A whole payload can therefore stream through one address. The pointer wraps from 0xFF to 0x00. A flag register at 0x12 collects event bits. Modem logic sets them through a parallel set-strobe input, and the host clears them by writing ones. Address 0x42 returns a fixed identification value. The transmit and receive base registers at 0x0E and 0x0F reset to 0x80 and 0x00. All other addresses are plain read/write storage that resets to zero.

The SPI pins are brought into the system clock domain with a two-stage synchroniser. The system clock must be well above the SPI clock: the bench runs SCLK at one sixteenth of it.

Top module: `spi_regmap_slave`

## Requirements
- R1: The first byte after chip select falls is a command byte: bit 7 = 1 selects write, bit 7 = 0 selects read, and bits 6:0 give the starting register address.
- R2: Bits are taken from MOSI on SCLK rising edges and MISO changes after falling edges, MSB first. On a read, the addressed register's value is shifted out during the byte that follows the command byte.
- R3: In a burst at any address other than 0x00, each further data byte accesses the next register address, for both reads and writes.
- R4: In a burst at address 0x00 the register address does not advance. Each data byte reads or writes the buffer entry selected by the pointer at 0x0D, and the pointer then increments by one.
- R5: The buffer pointer wraps from 0xFF to 0x00, for both buffer reads and buffer writes.
- R6: After reset, 0x0E reads 0x80, 0x0F reads 0x00, the pointer at 0x0D reads 0x00 and the flag register at 0x12 reads 0x00.
- R7: Writing the flag register at 0x12 clears each bit written as 1 and leaves each bit written as 0 unchanged. A high bit b on `evt_set_i` for one clock sets flag bit b; bit 6 marks receive done and bit 3 marks transmit done.
- R8: If an event sets a flag in the same clock cycle as a host write that clears it, the flag stays set. A host write takes effect on the third rising system-clock edge after the SCLK rising edge that completes its data byte.
- R9: Address 0x42 reads 0x12 and ignores writes.
- R10: If chip select rises before a byte is complete, that partial byte changes no register, no buffer entry and no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock from the host, Mode 0 |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from the host |
| miso_o | output | 1 | SPI data to the host |
| evt_set_i | input | 8 | Per-bit set strobes for the flag register from modem logic |

## Verification
The host's write-one-to-clear on the flag register and a modem event setting the same flag can land in the same system-clock cycle. The bench provokes this by aligning all SPI pin changes to the falling system-clock edge. It then pulses `evt_set_i` for a single cycle at a fixed offset from the SCLK rise that completes the clearing write: one offset hits the write's update edge and one falls a cycle earlier. The flag is read back over SPI afterwards. It must be set for the coincident pulse and cleared for the earlier one, so the bench can tell which side wins the collision.

// File: rtl/spi_regmap_pkg.sv
package spi_regmap_pkg;
  localparam logic [6:0] A_PORT    = 7'h00;
  localparam logic [6:0] A_PTR     = 7'h0D;
  localparam logic [6:0] A_TXBASE  = 7'h0E;
  localparam logic [6:0] A_RXBASE  = 7'h0F;
  localparam logic [6:0] A_FLAGS   = 7'h12;
  localparam logic [6:0] A_VERSION = 7'h42;
  localparam logic [7:0] VERSION_VAL = 8'h12;
  localparam int FLAG_RX_DONE = 6;
  localparam int FLAG_TX_DONE = 3;

  function automatic logic [7:0] reg_reset_val(input logic [6:0] a);
    return (a == A_TXBASE) ? 8'h80 : 8'h00;
  endfunction

  // storage-backed addresses (no side effects, no special read source)
  function automatic logic is_plain(input logic [6:0] a);
    return !(a == A_PORT || a == A_PTR || a == A_FLAGS || a == A_VERSION);
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic rise_o,
  output logic fall_o,
  output logic cs_act_o,
  output logic mosi_o
);
  localparam int W = 3;
  localparam logic [W-1:0] IDLE = 3'b010; // {sclk, csn, mosi}

  logic [W-1:0] stg_q [STAGES];
  logic         sclk_d_q;
  logic [W-1:0] sync_w;

  assign sync_w = stg_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= IDLE;
      sclk_d_q <= 1'b0;
    end else begin
      stg_q[0] <= {sclk_i, csn_i, mosi_i};
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      sclk_d_q <= sync_w[2];
    end
  end

  assign rise_o   = sync_w[2] & ~sclk_d_q;
  assign fall_o   = ~sync_w[2] & sclk_d_q;
  assign cs_act_o = ~sync_w[1];
  assign mosi_o   = sync_w[0];
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              byte_done_o,
  output logic              is_cmd_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              miso_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-2:0] rx_sr_q;
  logic [DATA_W-1:0] tx_sr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              first_q;

  assign rx_byte_o   = {rx_sr_q, mosi_i};
  assign byte_done_o = cs_act_i & rise_i & (cnt_q == LAST);
  assign is_cmd_o    = first_q;
  assign bit_cnt_o   = cnt_q;
  assign miso_o      = tx_sr_q[DATA_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sr_q <= '0;
      tx_sr_q <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (!cs_act_i) begin
      // window closed: any partial byte is dropped here
      tx_sr_q <= '0;
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (rise_i) begin
      rx_sr_q <= rx_byte_o[DATA_W-2:0];
      cnt_q   <= cnt_q + CNT_W'(1);
      if (cnt_q == LAST) begin
        first_q <= 1'b0;
        tx_sr_q <= tx_data_i;
      end
    end else if (fall_i && cnt_q != '0) begin
      // no shift on the fall that opens a byte: its MSB is already out
      tx_sr_q <= {tx_sr_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spi_regmap_core.sv
module spi_regmap_core
  import spi_regmap_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 256,
  localparam int BUF_AW   = $clog2(BUF_DEPTH),
  localparam int REG_N    = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_done_i,
  input  logic              is_cmd_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic [DATA_W-1:0] evt_set_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              wr_mode_o,
  output logic [BUF_AW-1:0] ptr_o,
  output logic [DATA_W-1:0] flags_o
);
  localparam logic [BUF_AW-1:0] PTR_ONE  = BUF_AW'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [DATA_W-1:0] regs_q [REG_N];
  logic [DATA_W-1:0] buf_q  [BUF_DEPTH];
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [BUF_AW-1:0] ptr_q;
  logic [DATA_W-1:0] flags_q;

  logic              data_byte, do_wr, do_rd, at_port;
  logic [ADDR_W-1:0] next_addr, rd_addr;
  logic [BUF_AW-1:0] buf_raddr;
  logic [DATA_W-1:0] flags_d;

  assign data_byte = byte_done_i & ~is_cmd_i;
  assign do_wr     = data_byte & wr_q;
  assign do_rd     = data_byte & ~wr_q;
  assign at_port   = (addr_q == A_PORT);
  assign next_addr = at_port ? addr_q : addr_q + ADDR_ONE;

  // read-ahead: value for the byte that starts after this one completes
  assign rd_addr   = is_cmd_i ? rx_byte_i[ADDR_W-1:0] : next_addr;
  assign buf_raddr = is_cmd_i ? ptr_q : ptr_q + PTR_ONE;

  always_comb begin
    unique case (rd_addr)
      A_PORT:    tx_data_o = buf_q[buf_raddr];
      A_PTR:     tx_data_o = DATA_W'(ptr_q);
      A_FLAGS:   tx_data_o = flags_q;
      A_VERSION: tx_data_o = VERSION_VAL;
      default:   tx_data_o = regs_q[rd_addr];
    endcase
  end

  always_comb begin
    flags_d = flags_q;
    if (do_wr && addr_q == A_FLAGS) flags_d = flags_d & ~rx_byte_i;
    flags_d = flags_d | evt_set_i; // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      ptr_q   <= '0;
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
      if (byte_done_i && is_cmd_i) begin
        wr_q   <= rx_byte_i[DATA_W-1];
        addr_q <= rx_byte_i[ADDR_W-1:0];
      end else if (data_byte) begin
        addr_q <= next_addr;
        if (at_port)                    ptr_q <= ptr_q + PTR_ONE;
        else if (do_wr && addr_q == A_PTR) ptr_q <= rx_byte_i[BUF_AW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < REG_N; a++) regs_q[a] <= reg_reset_val(a[6:0]);
    end else if (do_wr && is_plain(addr_q)) begin
      regs_q[addr_q] <= rx_byte_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr && at_port) buf_q[ptr_q] <= rx_byte_i;
  end

  assign cur_addr_o = addr_q;
  assign wr_mode_o  = wr_q;
  assign ptr_o      = ptr_q;
  assign flags_o    = flags_q;

  logic unused_rd;
  assign unused_rd = do_rd;
endmodule

// File: rtl/spi_regmap_slave.sv
module spi_regmap_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int BUF_DEPTH   = 256,
  parameter int SYNC_STAGES = 2,
  localparam int BUF_AW     = $clog2(BUF_DEPTH),
  localparam int CNT_W      = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic [DATA_W-1:0] evt_set_i
);
  logic              rise, fall, cs_act, mosi_s;
  logic              byte_done, is_cmd, wr_mode;
  logic [DATA_W-1:0] rx_byte, tx_data, flags;
  logic [ADDR_W-1:0] cur_addr;
  logic [BUF_AW-1:0] ptr;
  logic [CNT_W-1:0]  bit_cnt;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .csn_i, .mosi_i,
    .rise_o(rise), .fall_o(fall), .cs_act_o(cs_act), .mosi_o(mosi_s)
  );

  spi_byte_engine #(.DATA_W(DATA_W)) u_eng (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .rise_i(rise), .fall_i(fall), .mosi_i(mosi_s),
    .tx_data_i(tx_data), .byte_done_o(byte_done), .is_cmd_o(is_cmd),
    .rx_byte_o(rx_byte), .bit_cnt_o(bit_cnt), .miso_o
  );

  spi_regmap_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_DEPTH(BUF_DEPTH)) u_core (
    .clk_i, .rst_ni,
    .byte_done_i(byte_done), .is_cmd_i(is_cmd), .rx_byte_i(rx_byte),
    .evt_set_i, .tx_data_o(tx_data), .cur_addr_o(cur_addr),
    .wr_mode_o(wr_mode), .ptr_o(ptr), .flags_o(flags)
  );
endmodule

// File: rtl/spi_regmap_slave_chk.sv
module spi_regmap_slave_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int BUF_AW = 8,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act,
  input logic              byte_done,
  input logic              is_cmd,
  input logic              wr_mode,
  input logic [DATA_W-1:0] rx_byte,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [BUF_AW-1:0] ptr,
  input logic [DATA_W-1:0] flags,
  input logic [DATA_W-1:0] evt_set_i,
  input logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [ADDR_W-1:0] FLAG_A   = ADDR_W'(7'h12);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [BUF_AW-1:0] PTR_ONE  = BUF_AW'(1);

  logic flag_wr;
  assign flag_wr = byte_done & ~is_cmd & wr_mode & (cur_addr == FLAG_A);

  p_cmd_latch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && is_cmd |=> cur_addr == $past(rx_byte[ADDR_W-1:0]) && wr_mode == $past(rx_byte[DATA_W-1]));

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !is_cmd && cur_addr != '0 |=> cur_addr == $past(cur_addr) + ADDR_ONE);

  p_port_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done && !is_cmd && cur_addr == '0 |=> cur_addr == '0 && ptr == $past(ptr) + PTR_ONE);

  p_flag_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(flag_wr) |-> (flags & $past(flags)) == $past(flags));

  p_evt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_set_i != '0 |=> (flags & $past(evt_set_i)) == $past(evt_set_i));

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |-> !byte_done);

  p_cnt_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> bit_cnt == '0);
endmodule

bind spi_regmap_slave spi_regmap_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_AW(BUF_AW), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_act(cs_act), .byte_done(byte_done),
  .is_cmd(is_cmd), .wr_mode(wr_mode), .rx_byte(rx_byte), .cur_addr(cur_addr),
  .ptr(ptr), .flags(flags), .evt_set_i(evt_set_i), .bit_cnt(bit_cnt)
);

// File: tb/spi_regmap_slave_test.sv
module spi_regmap_slave_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso;
  logic [7:0] evt = '0;
  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  spi_regmap_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn),
    .mosi_i(mosi), .miso_o(miso), .evt_set_i(evt)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  // nbytes full bytes, then part_bits of one more; optional event pulse
  // evt_off posedges after the final rise of the last full byte
  task automatic frame(input int nbytes, input int part_bits, input int evt_off, input logic [7:0] evt_val);
    int total;
    total = nbytes + ((part_bits > 0) ? 1 : 0);
    @(negedge clk); csn = 1'b0; half();
    for (int i = 0; i < total; i++) begin
      rx_b[i] = '0;
      for (int b = 7; b >= 0; b--) begin
        if (i == nbytes && (7 - b) >= part_bits) break;
        mosi = tx_b[i][b];
        half();
        rx_b[i][b] = miso;
        sclk = 1'b1;
        if (evt_off >= 0 && i == nbytes - 1 && b == 0) begin
          repeat (evt_off) @(posedge clk);
          @(negedge clk); evt = evt_val;
          @(negedge clk); evt = '0;
        end
        half();
        sclk = 1'b0;
      end
    end
    half();
    csn = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] v);
    tx_b[0] = {1'b1, a}; tx_b[1] = v;
    frame(2, 0, -1, '0);
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] v);
    tx_b[0] = {1'b0, a}; tx_b[1] = '0;
    frame(2, 0, -1, '0);
    v = rx_b[1];
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset();
    tx_b[0] = {1'b0, 7'h0D}; tx_b[1] = '0; tx_b[2] = '0; tx_b[3] = '0;
    frame(4, 0, -1, '0);
    chk("R6 ptr reset", rx_b[1], 8'h00);
    chk("R6 txbase reset", rx_b[2], 8'h80);
    chk("R6 rxbase reset", rx_b[3], 8'h00);
    begin logic [7:0] v; rd1(7'h12, v); chk("R6 flags reset", v, 8'h00); end
  endtask

  task automatic t_version();
    logic [7:0] v;
    rd1(7'h42, v); chk("R9 version", v, 8'h12);
    wr1(7'h42, 8'hFF);
    rd1(7'h42, v); chk("R9 version after write", v, 8'h12);
  endtask

  task automatic t_single();
    logic [7:0] v;
    wr1(7'h05, 8'hA5);
    rd1(7'h05, v); chk("R1 R2 single rw", v, 8'hA5);
    wr1(7'h05, 8'h3C);
    rd1(7'h05, v); chk("R1 R2 overwrite", v, 8'h3C);
  endtask

  task automatic t_burst();
    tx_b[0] = {1'b1, 7'h20};
    tx_b[1] = 8'h11; tx_b[2] = 8'h22; tx_b[3] = 8'h33; tx_b[4] = 8'h44;
    frame(5, 0, -1, '0);
    tx_b[0] = {1'b0, 7'h20};
    for (int k = 1; k < 5; k++) tx_b[k] = '0;
    frame(5, 0, -1, '0);
    for (int k = 1; k < 5; k++) chk("R3 burst", rx_b[k], 8'(k * 8'h11));
  endtask

  task automatic t_port();
    logic [7:0] v;
    wr1(7'h0D, 8'h10);
    tx_b[0] = {1'b1, 7'h00};
    tx_b[1] = 8'hDE; tx_b[2] = 8'hAD; tx_b[3] = 8'hBE; tx_b[4] = 8'hEF;
    frame(5, 0, -1, '0);
    rd1(7'h0D, v); chk("R4 ptr after write burst", v, 8'h14);
    wr1(7'h0D, 8'h10);
    tx_b[0] = {1'b0, 7'h00};
    for (int k = 1; k < 5; k++) tx_b[k] = '0;
    frame(5, 0, -1, '0);
    chk("R4 port rd0", rx_b[1], 8'hDE);
    chk("R4 port rd1", rx_b[2], 8'hAD);
    chk("R4 port rd2", rx_b[3], 8'hBE);
    chk("R4 port rd3", rx_b[4], 8'hEF);
    rd1(7'h0D, v); chk("R4 ptr after read burst", v, 8'h14);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    wr1(7'h0D, 8'hFE);
    tx_b[0] = {1'b1, 7'h00}; tx_b[1] = 8'h5A; tx_b[2] = 8'h6B; tx_b[3] = 8'h7C;
    frame(4, 0, -1, '0);
    rd1(7'h0D, v); chk("R5 ptr wrap on write", v, 8'h01);
    wr1(7'h0D, 8'hFE);
    tx_b[0] = {1'b0, 7'h00}; tx_b[1] = '0; tx_b[2] = '0; tx_b[3] = '0;
    frame(4, 0, -1, '0);
    chk("R5 wrap rd FE", rx_b[1], 8'h5A);
    chk("R5 wrap rd FF", rx_b[2], 8'h6B);
    chk("R5 wrap rd 00", rx_b[3], 8'h7C);
    rd1(7'h0D, v); chk("R5 ptr wrap on read", v, 8'h01);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    pulse_evt(8'h48);
    rd1(7'h12, v); chk("R7 events set bits 6 and 3", v, 8'h48);
    wr1(7'h12, 8'h08);
    rd1(7'h12, v); chk("R7 clear bit 3 only", v, 8'h40);
    wr1(7'h12, 8'h00);
    rd1(7'h12, v); chk("R7 write zero keeps", v, 8'h40);
    wr1(7'h12, 8'hFF);
    rd1(7'h12, v); chk("R7 clear all", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    pulse_evt(8'h40);
    tx_b[0] = {1'b1, 7'h12}; tx_b[1] = 8'h40;
    frame(2, 0, 1, 8'h40); // event one cycle before the clear
    rd1(7'h12, v); chk("R8 early event cleared", v, 8'h00);
    pulse_evt(8'h40);
    tx_b[0] = {1'b1, 7'h12}; tx_b[1] = 8'h40;
    frame(2, 0, 2, 8'h40); // event on the clear cycle
    rd1(7'h12, v); chk("R8 same-cycle set wins", v, 8'h40);
    wr1(7'h12, 8'hFF);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    wr1(7'h0D, 8'h30);
    tx_b[0] = {1'b1, 7'h00}; tx_b[1] = 8'hC3;
    frame(1, 5, -1, '0);
    rd1(7'h0D, v); chk("R10 ptr unchanged by partial", v, 8'h30);
    wr1(7'h07, 8'h99);
    tx_b[0] = {1'b1, 7'h06}; tx_b[1] = 8'h12; tx_b[2] = 8'hE7;
    frame(2, 6, -1, '0);
    rd1(7'h06, v); chk("R10 full byte written", v, 8'h12);
    rd1(7'h07, v); chk("R10 partial byte dropped", v, 8'h99);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_version();
    t_single();
    t_burst();
    t_port();
    t_wrap();
    t_flags();
    t_collide();
    t_partial();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule